// File: doc/BRIEF.md
# Quadrature Encoder Mode Counter

This block keeps an up/down position count for a rotary or linear encoder. It can also run as a plain up counter on the system clock. Two raw phase inputs, A and B, are brought into the clock domain through a two-flop synchroniser. Their transitions are compared with the previous synchronised sample, and at most one count step is taken per clock cycle. A 2-bit mode field selects which transitions are counted.

Software reaches the block through a small register port. There is one write strobe with an address and data, and one combinational read address. Through it, software sets the mode and enable, programs a ceiling that the count wraps at, reads or loads the count, and reads the direction of the last step. Writing the control word with the update bit set clears the count and the direction and resynchronises the edge history. A safe mode change therefore runs: disable, write the new mode with the update bit, re-enable. Every pin is plain control or status. No data stream crosses the boundary, so no pin carries a valid/ready handshake.

Top module: `qenc_counter`

## Requirements
- R1: In mode 0 (control bits [1:0] = 0), with enable (control bit 2) set, the count rises by one on every clock cycle and the A/B inputs have no effect.
- R2: In mode 1, each transition of A is one step and B transitions are ignored. The step is up when A and B differ after the transition, and down when they are equal.
- R3: In mode 2, each transition of B is one step and A transitions are ignored. The step is up when A and B are equal after the transition, and down when they differ.
- R4: In mode 3, a transition of A alone follows the R2 rule and a transition of B alone follows the R3 rule. When both change in the same synchronised sample, no step is taken.
- R5: An up step from a count at or above the ceiling gives 0. A down step from 0 gives the ceiling value.
- R6: The direction flag (status register, address 3, bit 0) becomes 1 after a down step and 0 after an up step, and holds between steps.
- R7: A write to the ceiling register (address 1) governs the very next step, with no buffering.
- R8: A count write (address 2) with a value above the current ceiling is dropped. A value equal to or below it is loaded.
- R9: With enable clear, the count and direction never change through counting. Mode, ceiling and count keep their values across disable and re-enable.
- R10: A control write (address 0) with bit 3 set forces the count and the direction to 0 in the next cycle. Bit 3 always reads as 0.
- R11: A change on a raw input reaches the count on the third rising clock edge after it is first sampled.
- R12: After reset, control reads 0, the ceiling reads all ones, and the count and direction read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_a_i | input | 1 | Raw phase A input |
| quad_b_i | input | 1 | Raw phase B input |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 2 | Write address: 0 control, 1 ceiling, 2 count |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address: 0 control, 1 ceiling, 2 count, 3 status |
| rd_data_o | output | CNT_W | Combinational read data for rd_addr_i |

## Verification
The assertions assume only one register write per cycle, and that the rejected-load property is checked only while counting is disabled, since an enabled count may step in the same cycle. The wrap properties assume that load and update outrank a pending step, which is the priority the brief fixes. The stimulus keeps to these limits. It issues a single write at a time and performs the reject and accept loads with enable cleared. Its phase changes are proper Gray steps, held for one or more cycles, apart from one deliberate double transition that exercises the no-step rule of mode 3.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_CLK = 2'd0,
    MODE_A   = 2'd1,
    MODE_B   = 2'd2,
    MODE_AB  = 2'd3
  } qmode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CEIL = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_EN_BIT  = 2;
  localparam int CTRL_UPD_BIT = 3;
  localparam int CTRL_W       = 4;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_i,      // [0] = A, [1] = B, synchronised
  input  qmode_e     mode_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       step_up_o,
  output logic       step_dn_o
);

  logic [1:0] prev_q;
  logic [1:0] edge_w;
  logic       phase_ne;

  // per-lane transition detect against the previous synchronised sample
  for (genvar c = 0; c < 2; c++) begin : g_lane
    assign edge_w[c] = lvl_i[c] ^ prev_q[c];
  end

  assign phase_ne = lvl_i[0] ^ lvl_i[1];

  always_comb begin
    step_up_o = 1'b0;
    step_dn_o = 1'b0;
    if (en_i && !clr_i) begin
      unique case (mode_i)
        MODE_CLK: step_up_o = 1'b1;
        MODE_A: if (edge_w[0]) {step_up_o, step_dn_o} = phase_ne ? 2'b10 : 2'b01;
        MODE_B: if (edge_w[1]) {step_up_o, step_dn_o} = phase_ne ? 2'b01 : 2'b10;
        MODE_AB: begin
          if (edge_w == 2'b01)      {step_up_o, step_dn_o} = phase_ne ? 2'b10 : 2'b01;
          else if (edge_w == 2'b10) {step_up_o, step_dn_o} = phase_ne ? 2'b01 : 2'b10;
        end
        default: ;
      endcase
    end
  end

  // history always follows the inputs; an update therefore restarts it
  // from the present levels and no stale transition survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !(step_up_o || step_dn_o));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up_o && step_dn_o));

  assert_mode0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && mode_i == MODE_CLK) |-> step_up_o);

endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             clr_i,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] ceil_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (clr_i) begin
      cnt_d = '0;
      dir_d = 1'b0;
    end else if (load_en_i) begin
      cnt_d = load_val_i;
    end else if (step_up_i) begin
      cnt_d = (cnt_q >= ceil_i) ? '0 : cnt_q + 1'b1;
      dir_d = 1'b0;
    end else if (step_dn_i) begin
      cnt_d = (cnt_q == '0) ? ceil_i : cnt_q - 1'b1;
      dir_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_i && !clr_i && !load_en_i && cnt_q >= ceil_i) |=> cnt_q == '0);

  assert_wrap_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn_i && !step_up_i && !clr_i && !load_en_i && cnt_q == '0) |=> cnt_q == $past(ceil_i));

  assert_dir_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn_i && !step_up_i && !clr_i && !load_en_i) |=> dir_q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up_i && !step_dn_i && !clr_i && !load_en_i) |=> ($stable(cnt_q) && $stable(dir_q)));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_a_i,
  input  logic             quad_b_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);

  localparam int CTRL_PAD = CNT_W - CTRL_W + 1;
  localparam int STAT_PAD = CNT_W - 1;

  qmode_e           mode_q;
  logic             en_q;
  logic [CNT_W-1:0] ceil_q;
  logic [CNT_W-1:0] cnt_w;
  logic             dir_w;
  logic [1:0]       lvl_w;
  logic             step_up_w, step_dn_w;
  logic             wr_ctrl, wr_ceil, wr_cnt, upd_w, load_ok;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_ceil = wr_en_i && (wr_addr_i == ADDR_CEIL);
  assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign upd_w   = wr_ctrl && wr_data_i[CTRL_UPD_BIT];
  assign load_ok = wr_cnt && (wr_data_i <= ceil_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CLK;
      en_q   <= 1'b0;
      ceil_q <= '1;
    end else begin
      if (wr_ctrl) begin
        mode_q <= qmode_e'(wr_data_i[1:0]);
        en_q   <= wr_data_i[CTRL_EN_BIT];
      end
      if (wr_ceil) ceil_q <= wr_data_i;
    end
  end

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({quad_b_i, quad_a_i}),
    .sync_o  (lvl_w)
  );

  qenc_decoder dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl_w),
    .mode_i    (mode_q),
    .en_i      (en_q),
    .clr_i     (upd_w),
    .step_up_o (step_up_w),
    .step_dn_o (step_dn_w)
  );

  qenc_core #(.CNT_W(CNT_W)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_up_i  (step_up_w),
    .step_dn_i  (step_dn_w),
    .clr_i      (upd_w),
    .load_en_i  (load_ok),
    .load_val_i (wr_data_i),
    .ceil_i     (ceil_q),
    .cnt_o      (cnt_w),
    .dir_o      (dir_w)
  );

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o = {{CTRL_PAD{1'b0}}, en_q, mode_q};
      ADDR_CEIL: rd_data_o = ceil_q;
      ADDR_CNT:  rd_data_o = cnt_w;
      default:   rd_data_o = {{STAT_PAD{1'b0}}, dir_w};
    endcase
  end

  assert_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_w |=> (cnt_w == '0 && !dir_w));

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !en_q && wr_data_i > ceil_q) |=> $stable(cnt_w));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && wr_data_i <= ceil_q) |=> cnt_w == $past(wr_data_i));

endmodule

// File: tb/qenc_counter_tb.sv
`timescale 1ns/1ps
module qenc_counter_tb_top;

  localparam int W    = 16;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         qa = 1'b0, qb = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;

  always #2 clk = ~clk;  // 250 MHz

  qenc_counter #(.CNT_W(W)) dut_i (
    .clk (clk), .rst_n (rst_n), .quad_a_i (qa), .quad_b_i (qb),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R12";
  bit chk_on = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_dir, m_mode, m_en, m_ceil;
  int s1a, s1b, s2a, s2b, pa, pb;
  bit m_up, m_dn, ea, eb, ne;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_mode = 0; m_en = 0; m_ceil = MAXV;
      s1a = 0; s1b = 0; s2a = 0; s2b = 0; pa = 0; pb = 0;
    end else begin
      m_up = 0; m_dn = 0;
      ea = (s2a != pa); eb = (s2b != pb); ne = (s2a != s2b);
      if (m_en != 0) begin
        if (m_mode == 0) m_up = 1;
        else if ((m_mode == 1 || m_mode == 3) && ea && !(m_mode == 3 && eb)) begin
          m_up = ne; m_dn = !ne;
        end else if ((m_mode == 2 || m_mode == 3) && eb && !(m_mode == 3 && ea)) begin
          m_up = !ne; m_dn = ne;
        end
      end
      if (wr_en && wr_addr == 0 && wr_data[3]) begin
        m_cnt = 0; m_dir = 0;
      end else if (wr_en && wr_addr == 2 && int'(wr_data) <= m_ceil) begin
        m_cnt = int'(wr_data);
      end else if (m_up) begin
        m_cnt = (m_cnt >= m_ceil) ? 0 : m_cnt + 1; m_dir = 0;
      end else if (m_dn) begin
        m_cnt = (m_cnt == 0) ? m_ceil : m_cnt - 1; m_dir = 1;
      end
      if (wr_en && wr_addr == 0) begin m_mode = int'(wr_data[1:0]); m_en = int'(wr_data[2]); end
      if (wr_en && wr_addr == 1) m_ceil = int'(wr_data);
      pa = s2a; pb = s2b; s2a = s1a; s2b = s1b; s1a = int'(qa); s1b = int'(qb);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      #0.3; rd_addr = 2'd2; #0.1; chk(cur_req, int'(rd_data), m_cnt);
      rd_addr = 2'd3; #0.1; chk({cur_req, "/R6"}, int'(rd_data), m_dir);
    end
  end

  // ---------------- stimulus helpers ----------------
  int gidx = 0;

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(string req, logic [1:0] a, int exp);
    @(negedge clk); #1.0; rd_addr = a; #0.2; chk(req, int'(rd_data), exp);
  endtask

  task automatic rdval(logic [1:0] a, output int v);
    @(negedge clk); #1.0; rd_addr = a; #0.2; v = int'(rd_data);
  endtask

  // Gray order (a,b): 00 -> 10 -> 11 -> 01
  task automatic gstep(int d, int hold);
    @(negedge clk);
    gidx = (gidx + d) & 3;
    qa = (gidx == 1 || gidx == 2);
    qb = (gidx == 2 || gidx == 3);
    repeat (hold - 1) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int v0, v1;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    // R12 reset values
    rdchk("R12", 2'd0, 0);
    rdchk("R12", 2'd1, MAXV);
    rdchk("R12", 2'd2, 0);
    rdchk("R12", 2'd3, 0);

    // R1 + R5: free count with small ceiling, inputs toggling
    cur_req = "R1";
    wr(2'd1, 9);
    wr(2'd0, 4);
    for (int i = 0; i < 30; i++) gstep(((i % 5) == 0) ? -1 : 1, 1);

    // R9: disable freezes the count; registers kept
    cur_req = "R9";
    wr(2'd0, 0);
    rdval(2'd2, v0);
    for (int i = 0; i < 6; i++) gstep(1, 2);
    rdchk("R9", 2'd2, v0);
    wr(2'd0, 3);
    for (int i = 0; i < 6; i++) gstep(1, 2);
    rdchk("R9", 2'd2, v0);
    rdchk("R9", 2'd0, 3);
    rdchk("R9", 2'd1, 9);

    // R8: load rejection and boundary acceptance (disabled)
    cur_req = "R8";
    wr(2'd2, 50);  rdchk("R8", 2'd2, v0);
    wr(2'd2, 9);   rdchk("R8", 2'd2, 9);
    wr(2'd2, 10);  rdchk("R8", 2'd2, 9);

    // R10: update clears count and dir, bit 3 reads back 0
    cur_req = "R10";
    wr(2'd1, 1000);
    wr(2'd0, 8 | 1);
    rdchk("R10", 2'd2, 0);
    rdchk("R10", 2'd0, 1);

    // R2: mode 1
    cur_req = "R2";
    wr(2'd2, 100);
    wr(2'd0, 4 | 1);
    for (int i = 0; i < 8; i++) gstep(1, 3);
    idle(4); rdchk("R2", 2'd2, 104);
    for (int i = 0; i < 8; i++) gstep(-1, 3);
    idle(4); rdchk("R2", 2'd2, 100);
    rdchk("R2", 2'd3, 1);

    // R3: mode 2 after a clean mode change
    cur_req = "R3";
    wr(2'd0, 0);
    wr(2'd0, 8 | 2);
    wr(2'd2, 100);
    wr(2'd0, 4 | 2);
    for (int i = 0; i < 8; i++) gstep(1, 3);
    idle(4); rdchk("R3", 2'd2, 104);

    // R4: mode 3, including a double transition
    cur_req = "R4";
    wr(2'd0, 0);
    wr(2'd0, 8 | 3);
    wr(2'd2, 100);
    wr(2'd0, 4 | 3);
    for (int i = 0; i < 8; i++) gstep(1, 2);
    idle(4); rdchk("R4", 2'd2, 108);
    @(negedge clk); qa = ~qa; qb = ~qb; gidx = (gidx + 2) & 3;
    idle(5); rdchk("R4", 2'd2, 108);
    for (int i = 0; i < 6; i++) gstep(1, 1);
    idle(4); rdchk("R4", 2'd2, 114);

    // R5: down wrap from 0
    cur_req = "R5";
    wr(2'd2, 1);
    for (int i = 0; i < 3; i++) gstep(-1, 3);
    idle(4); rdchk("R5", 2'd2, 999);
    rdchk("R6", 2'd3, 1);

    // R7: ceiling lowered below count acts on next step
    cur_req = "R7";
    wr(2'd2, 20);
    wr(2'd1, 15);
    gstep(1, 3);
    idle(4); rdchk("R7", 2'd2, 0);
    rdchk("R6", 2'd3, 0);
    gstep(1, 1);
    idle(4); rdchk("R7", 2'd2, 1);

    // R11: latency through synchroniser and history
    cur_req = "R11";
    @(negedge clk); gidx = (gidx + 1) & 3;
    qa = (gidx == 1 || gidx == 2); qb = (gidx == 2 || gidx == 3);
    rdchk("R11", 2'd2, 1);
    rdchk("R11", 2'd2, 1);
    rdchk("R11", 2'd2, 2);

    // R1: mode 0 again after re-enable with held registers
    cur_req = "R1";
    wr(2'd1, 50);
    wr(2'd0, 8 | 0);
    wr(2'd0, 4 | 0);
    for (int i = 0; i < 20; i++) gstep(1, 1);
    wr(2'd0, 0);
    rdval(2'd2, v1);
    idle(3);
    rdchk("R9", 2'd2, v1);

    idle(2);
    chk_on = 1'b0;
    idle(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule